// File: doc/BRIEF.md
# Scalar Memory Clause Conflict Detector

This block watches the instruction issue stream and keeps a short history of what went out in each slot. The newest entries that are all scalar-memory operations, with no gap between them, form the current clause. The block holds each entry's destination and source registers as bit-vectors. It merges the masks of every clause member into one set of written registers and one set of read registers.

A scheduler offers a candidate instruction every cycle. If the candidate is a scalar-memory operation, the block tells the scheduler whether adding it to the clause is unsafe. Clause members can complete out of order and can be replayed, so no register that any member writes may be read by any member. This includes an instruction that reads its own destination. Every store also closes the clause. When the break flag is high, the scheduler issues a filler instruction instead. The filler enters the history as a non-memory entry, which empties the clause from the next cycle on.

The issue port carries no ready signal. The block accepts one slot on every rising edge and never applies back-pressure. A slot with valid low counts as an empty issue cycle. The candidate inputs and the break flag are plain combinational control.

Top module: `smem_clause_guard`

## Requirements
- R1: The clause consists of the newest history entries that were issued valid with the scalar-memory flag set, stopping at the first entry that is empty (valid low) or is a different instruction type; entries beyond that stop contribute nothing.
- R2: With `mode_new` low (older-generation mode) `brk_need` is 0 whatever the other inputs are.
- R3: If the candidate is not valid or is not a scalar-memory operation, `brk_need` is 0.
- R4: If no clause member has an enabled destination register, `brk_need` is 0, even for a store candidate or a candidate that reads its own destination.
- R5: A valid scalar-memory candidate with `cand_store` high gives `brk_need` = 1 when the clause holds at least one destination register (mode_new high).
- R6: Otherwise `brk_need` is 1 when the union of clause and candidate destinations shares a register with the union of clause and candidate sources, including a candidate that reads the register it writes.
- R7: When those two unions are disjoint and the candidate is not a store, `brk_need` is 0.
- R8: The history holds the last 5 issue slots; a slot issued 6 or more cycles before the candidate no longer affects `brk_need`.
- R9: A synchronous active-high `rst` empties the history, so the first candidate after reset sees an empty clause.
- R10: `brk_need` follows the candidate inputs in the same cycle, with no clock edge between them.
- R11: A register ID whose enable bit is low (`*_src_en[i]`, `*_dst_en`) is ignored, both in issued slots and in the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_new | input | 1 | 1 enables the check (newer generation), 0 forces the flag low |
| iss_valid | input | 1 | An instruction was issued this cycle (0 = empty slot) |
| iss_smem | input | 1 | Issued instruction is a scalar-memory operation |
| iss_src_id | input | NSRC*IDW (2x6) | Source register IDs of the issued instruction |
| iss_src_en | input | NSRC (2) | Per-source enable |
| iss_dst_id | input | IDW (6) | Destination register ID of the issued instruction |
| iss_dst_en | input | 1 | Destination enable |
| cand_valid | input | 1 | Candidate present |
| cand_smem | input | 1 | Candidate is a scalar-memory operation |
| cand_store | input | 1 | Candidate is a store |
| cand_src_id | input | NSRC*IDW (2x6) | Candidate source register IDs |
| cand_src_en | input | NSRC (2) | Candidate per-source enable |
| cand_dst_id | input | IDW (6) | Candidate destination register ID |
| cand_dst_en | input | 1 | Candidate destination enable |
| brk_need | output | 1 | A filler must be issued before the candidate |

## Verification
A history stage that shifts wrongly, or a clause cut applied at the wrong entry, shows at `brk_need` as a spurious or missing break. The first candidate that reads a register written a few slots back exposes it in the same cycle. A depth error shows up exactly five issues after a conflicting writer, when the flag must drop. A stale entry left behind by reset shows up in the first cycle after reset, as a break for a store candidate. Mistakes in the intersection or the store rule change the flag the moment the candidate inputs change, so a cycle-by-cycle comparison catches them without delay.

// File: rtl/smcg_pkg.sv
package smcg_pkg;
  localparam int SMCG_NREG_DEF  = 64;
  localparam int SMCG_DEPTH_DEF = 5;
  localparam int SMCG_NSRC_DEF  = 2;
endpackage

// File: rtl/smcg_decode.sv
module smcg_decode #(
  parameter int NREG = 64,
  parameter int N    = 1,
  localparam int IDW = $clog2(NREG)
) (
  input  logic [N-1:0][IDW-1:0] ids,
  input  logic [N-1:0]          en,
  output logic [NREG-1:0]       mask
);
  always_comb begin
    mask = '0;
    for (int i = 0; i < N; i++) begin
      if (en[i]) mask[ids[i]] = 1'b1;
    end
  end
endmodule

// File: rtl/smcg_history.sv
module smcg_history #(
  parameter int NREG  = 64,
  parameter int DEPTH = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_smem,
  input  logic [NREG-1:0]            in_def,
  input  logic [NREG-1:0]            in_use,
  output logic [DEPTH-1:0]           smem,
  output logic [DEPTH-1:0][NREG-1:0] defs,
  output logic [DEPTH-1:0][NREG-1:0] uses
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic            s_q;
    logic [NREG-1:0] d_q;
    logic [NREG-1:0] u_q;
    logic            s_n;
    logic [NREG-1:0] d_n;
    logic [NREG-1:0] u_n;

    if (k == 0) begin : g_head
      assign s_n = in_smem;
      assign d_n = in_def;
      assign u_n = in_use;
    end else begin : g_tail
      assign s_n = smem[k-1];
      assign d_n = defs[k-1];
      assign u_n = uses[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s_q <= 1'b0;
        d_q <= '0;
        u_q <= '0;
      end else begin
        s_q <= s_n;
        d_q <= d_n;
        u_q <= u_n;
      end
    end

    assign smem[k] = s_q;
    assign defs[k] = d_q;
    assign uses[k] = u_q;
  end

  AST_HIST_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (smem == '0)); // R9
endmodule

// File: rtl/smcg_run_accum.sv
module smcg_run_accum #(
  parameter int NREG  = 64,
  parameter int DEPTH = 5
) (
  input  logic [DEPTH-1:0]           smem,
  input  logic [DEPTH-1:0][NREG-1:0] defs,
  input  logic [DEPTH-1:0][NREG-1:0] uses,
  output logic [NREG-1:0]            run_def,
  output logic [NREG-1:0]            run_use
);
  logic [DEPTH-1:0]           alive;
  logic [DEPTH-1:0][NREG-1:0] pd;
  logic [DEPTH-1:0][NREG-1:0] pu;

  for (genvar k = 0; k < DEPTH; k++) begin : g_chain
    if (k == 0) begin : g_first
      assign alive[0] = smem[0];
      assign pd[0]    = smem[0] ? defs[0] : '0;
      assign pu[0]    = smem[0] ? uses[0] : '0;
    end else begin : g_next
      assign alive[k] = alive[k-1] & smem[k];
      assign pd[k]    = pd[k-1] | (alive[k] ? defs[k] : '0);
      assign pu[k]    = pu[k-1] | (alive[k] ? uses[k] : '0);
    end
  end

  assign run_def = pd[DEPTH-1];
  assign run_use = pu[DEPTH-1];
endmodule

// File: rtl/smem_clause_guard.sv
module smem_clause_guard
  import smcg_pkg::*;
#(
  parameter int NREG  = SMCG_NREG_DEF,
  parameter int DEPTH = SMCG_DEPTH_DEF,
  parameter int NSRC  = SMCG_NSRC_DEF,
  localparam int IDW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_new,
  input  logic                     iss_valid,
  input  logic                     iss_smem,
  input  logic [NSRC-1:0][IDW-1:0] iss_src_id,
  input  logic [NSRC-1:0]          iss_src_en,
  input  logic [IDW-1:0]           iss_dst_id,
  input  logic                     iss_dst_en,
  input  logic                     cand_valid,
  input  logic                     cand_smem,
  input  logic                     cand_store,
  input  logic [NSRC-1:0][IDW-1:0] cand_src_id,
  input  logic [NSRC-1:0]          cand_src_en,
  input  logic [IDW-1:0]           cand_dst_id,
  input  logic                     cand_dst_en,
  output logic                     brk_need
);
  logic [NREG-1:0] iss_use, iss_def, cnd_use, cnd_def;
  logic            iss_keep;
  logic [NREG-1:0] hist_def_in, hist_use_in;
  logic [DEPTH-1:0]           h_smem;
  logic [DEPTH-1:0][NREG-1:0] h_def;
  logic [DEPTH-1:0][NREG-1:0] h_use;
  logic [NREG-1:0] run_def, run_use;
  logic [NREG-1:0] all_def, all_use;
  logic            cand_live, run_has_def, overlap;

  smcg_decode #(.NREG(NREG), .N(NSRC)) u_iss_src (
    .ids(iss_src_id), .en(iss_src_en), .mask(iss_use));
  smcg_decode #(.NREG(NREG), .N(1)) u_iss_dst (
    .ids(iss_dst_id), .en(iss_dst_en), .mask(iss_def));
  smcg_decode #(.NREG(NREG), .N(NSRC)) u_cnd_src (
    .ids(cand_src_id), .en(cand_src_en), .mask(cnd_use));
  smcg_decode #(.NREG(NREG), .N(1)) u_cnd_dst (
    .ids(cand_dst_id), .en(cand_dst_en), .mask(cnd_def));

  assign iss_keep    = iss_valid & iss_smem;
  assign hist_def_in = iss_keep ? iss_def : '0;
  assign hist_use_in = iss_keep ? iss_use : '0;

  smcg_history #(.NREG(NREG), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst(rst), .in_smem(iss_keep), .in_def(hist_def_in),
    .in_use(hist_use_in), .smem(h_smem), .defs(h_def), .uses(h_use));

  smcg_run_accum #(.NREG(NREG), .DEPTH(DEPTH)) u_run (
    .smem(h_smem), .defs(h_def), .uses(h_use),
    .run_def(run_def), .run_use(run_use));

  always_comb begin
    cand_live   = mode_new & cand_valid & cand_smem;
    run_has_def = |run_def;
    all_def     = run_def | cnd_def;
    all_use     = run_use | cnd_use;
    overlap     = |(all_def & all_use);
    brk_need    = cand_live & run_has_def & (cand_store | overlap);
  end

  AST_OLD_MODE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !mode_new |-> !brk_need); // R2
  AST_NON_SMEM_SILENT: assert property (@(posedge clk) disable iff (rst)
    !(cand_valid && cand_smem) |-> !brk_need); // R3
  AST_RUN_CUT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(iss_valid && iss_smem)) |-> !brk_need); // R1
  AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(iss_valid && iss_smem && iss_dst_en) && mode_new &&
     cand_valid && cand_smem && cand_store) |-> brk_need); // R5
  AST_SELF_CLASH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(iss_valid && iss_smem && iss_dst_en) && mode_new &&
     cand_valid && cand_smem && cand_dst_en && cand_src_en[0] &&
     cand_src_id[0] == cand_dst_id) |-> brk_need); // R6
endmodule

// File: tb/smem_clause_guard_test.sv
module smem_clause_guard_test;
  typedef struct {
    bit          sm;
    bit [63:0]   d;
    bit [63:0]   u;
  } hent_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_new = 1'b1;
  logic iss_valid = 1'b0, iss_smem = 1'b0, iss_dst_en = 1'b0;
  logic [1:0][5:0] iss_src_id = '0;
  logic [1:0] iss_src_en = '0;
  logic [5:0] iss_dst_id = '0;
  logic cand_valid = 1'b0, cand_smem = 1'b0, cand_store = 1'b0, cand_dst_en = 1'b0;
  logic [1:0][5:0] cand_src_id = '0;
  logic [1:0] cand_src_en = '0;
  logic [5:0] cand_dst_id = '0;
  logic brk_need;

  int n_chk = 0;
  int n_bad = 0;
  hent_t hq[$];

  always #2 clk = ~clk;

  smem_clause_guard uut (
    .clk(clk), .rst(rst), .mode_new(mode_new),
    .iss_valid(iss_valid), .iss_smem(iss_smem), .iss_src_id(iss_src_id),
    .iss_src_en(iss_src_en), .iss_dst_id(iss_dst_id), .iss_dst_en(iss_dst_en),
    .cand_valid(cand_valid), .cand_smem(cand_smem), .cand_store(cand_store),
    .cand_src_id(cand_src_id), .cand_src_en(cand_src_en),
    .cand_dst_id(cand_dst_id), .cand_dst_en(cand_dst_en), .brk_need(brk_need));

  task automatic set_iss(bit v, bit sm, int s0, bit e0, int s1, bit e1, int d, bit de);
    iss_valid = v; iss_smem = sm;
    iss_src_id[0] = s0[5:0]; iss_src_en[0] = e0;
    iss_src_id[1] = s1[5:0]; iss_src_en[1] = e1;
    iss_dst_id = d[5:0]; iss_dst_en = de;
  endtask

  task automatic set_cand(bit v, bit sm, bit st, int s0, bit e0, int s1, bit e1, int d, bit de);
    cand_valid = v; cand_smem = sm; cand_store = st;
    cand_src_id[0] = s0[5:0]; cand_src_en[0] = e0;
    cand_src_id[1] = s1[5:0]; cand_src_en[1] = e1;
    cand_dst_id = d[5:0]; cand_dst_en = de;
  endtask

  task automatic check_now(string tag);
    bit [63:0] rd, ru, cd, cu;
    bit exp;
    string t;
    rd = '0; ru = '0; cd = '0; cu = '0;
    foreach (hq[k]) begin
      if (!hq[k].sm) break;
      rd |= hq[k].d;
      ru |= hq[k].u;
    end
    if (cand_src_en[0]) cu[cand_src_id[0]] = 1'b1;
    if (cand_src_en[1]) cu[cand_src_id[1]] = 1'b1;
    if (cand_dst_en) cd[cand_dst_id] = 1'b1;
    if (!mode_new) begin exp = 1'b0; t = "R2"; end
    else if (!(cand_valid && cand_smem)) begin exp = 1'b0; t = "R3"; end
    else if (rd == 0) begin exp = 1'b0; t = "R4"; end
    else if (cand_store) begin exp = 1'b1; t = "R5"; end
    else if (((rd | cd) & (ru | cu)) != 0) begin exp = 1'b1; t = "R6"; end
    else begin exp = 1'b0; t = "R7"; end
    if (tag != "") t = tag;
    n_chk++;
    if (brk_need !== exp) begin
      n_bad++;
      $display("FAIL %s: brk_need=%0b expected %0b at %0t", t, brk_need, exp, $time);
    end
  endtask

  task automatic step(string tag);
    hent_t e;
    #1;
    if (!rst) check_now(tag);
    @(posedge clk);
    if (rst) hq.delete();
    else begin
      e.sm = iss_valid && iss_smem;
      e.d = '0; e.u = '0;
      if (e.sm) begin
        if (iss_dst_en) e.d[iss_dst_id] = 1'b1;
        if (iss_src_en[0]) e.u[iss_src_id[0]] = 1'b1;
        if (iss_src_en[1]) e.u[iss_src_id[1]] = 1'b1;
      end
      hq.push_front(e);
      if (hq.size() > 5) void'(hq.pop_back());
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(""); step("");
    rst = 1'b0;
    set_cand(1, 1, 1, 0, 0, 0, 0, 1, 1);
    step("R9");
    set_iss(1, 1, 1, 1, 0, 0, 4, 1); set_cand(0, 1, 0, 4, 1, 0, 0, 0, 0);
    step("R3");
    set_iss(1, 1, 2, 1, 0, 0, 9, 1); set_cand(1, 1, 0, 4, 1, 0, 0, 0, 0);
    step("R6");
    set_iss(0, 1, 0, 0, 0, 0, 0, 0); set_cand(1, 1, 0, 7, 1, 0, 0, 8, 1);
    step("R7");
    set_cand(1, 1, 0, 4, 1, 0, 0, 0, 0);
    step("R1");
    set_iss(1, 1, 10, 1, 0, 0, 3, 1); set_cand(1, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R4");
    set_iss(1, 1, 21, 1, 0, 0, 20, 1); set_cand(1, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R5");
    set_cand(1, 1, 0, 3, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R8");
    step("R8");
    set_cand(1, 1, 0, 20, 0, 0, 0, 21, 0);
    step("R11");
    set_cand(1, 1, 0, 20, 1, 0, 0, 0, 0);
    step("R6");
    set_cand(1, 1, 0, 30, 1, 0, 0, 30, 1);
    step("R6");
    mode_new = 1'b0; set_cand(1, 1, 1, 20, 1, 0, 0, 0, 0);
    step("R2");
    mode_new = 1'b1; set_cand(1, 1, 1, 0, 0, 0, 0, 0, 0);
    #1; check_now("R10");
    set_cand(1, 1, 0, 40, 1, 41, 1, 42, 1);
    #1; check_now("R10");
    step("R10");
    rst = 1'b1; step("");
    rst = 1'b0; set_cand(1, 1, 1, 20, 1, 0, 0, 20, 1);
    step("R9");
    for (int i = 0; i < 600; i++) begin
      mode_new = ($urandom_range(0, 9) != 0);
      rst = ($urandom_range(0, 99) == 0);
      set_iss($urandom_range(0, 9) != 0, $urandom_range(0, 4) != 0,
              $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 7),
              $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1));
      set_cand($urandom_range(0, 9) != 0, $urandom_range(0, 4) != 0,
               $urandom_range(0, 9) == 0, $urandom_range(0, 7), $urandom_range(0, 1),
               $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 7),
               $urandom_range(0, 1));
      step("");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule